// File: doc/BRIEF.md
# Floating-Point Register List Store Sequencer

This block turns one multiple-register store command into a series of memory store requests, one per floating-point register named in an 8-bit register list. The command word carries a direction bit, a two-bit list mode and the list itself. In one mode the list comes from a data register that the command names, rather than from the command word.

The sequencer scans the list from bit 0 upward. For each set bit it reads one 80-bit register through a read port into the floating-point register file. It zero-pads the value into a 96-bit slot and raises a store request that stays up until memory acknowledges it. Each accepted store moves the address on by 12 bytes and adds 2 to a cycle-cost count. The surrounding pipeline reports that count when the command ends. A command the block does not carry out ends in an error pulse instead of a done pulse.

Top module: `fpRegListStore`

## Requirements
- R1: After reset `done`, `error`, `stReq` and `busy` are all low.
- R2: The command word is decoded as: bit 13 direction (1 = registers to memory), bits 12:11 list mode, bits 7:0 register list; `start` is sampled only while `busy` is low.
- R3: In list mode 0, list bit i selects floating-point register i; bits are visited in ascending order and each set bit yields exactly one store.
- R4: In list mode 2, list bit i selects floating-point register 7-i, still visiting bits in ascending order.
- R5: In list mode 1, the list is the low 8 bits of the data register whose index is command bits 6:4; the transfer then proceeds as in mode 0.
- R6: The first store goes to `baseAddr` and every later store of the same command goes 12 bytes above the previous one.
- R7: `stData` carries the selected register value in bits 79:0 and zero in bits 95:80.
- R8: When `done` rises, `cycleCost` equals 2 times the number of stores of that command, and it holds that value until the next accepted `start`.
- R9: List mode 3, or direction 0, yields a one-cycle `error` pulse with no store request and a `cycleCost` of 0.
- R10: An empty register list yields a `done` pulse with no store request.
- R11: While `stReq` is high and `stAck` is low, `stReq`, `stAddr` and `stData` hold their values.
- R12: `done` and `error` are single-cycle pulses, never high together, and a `start` seen while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command while idle |
| cmdWord | input | 16 | Command word: direction, list mode, list |
| baseAddr | input | 32 | Byte address of the first store |
| dRegSel | output | 3 | Index into the data register file |
| dRegData | input | 32 | Data register read value |
| fpRegSel | output | 3 | Index into the floating-point register file |
| fpRegData | input | 80 | Floating-point register read value |
| stReq | output | 1 | Store request |
| stAddr | output | 32 | Store byte address |
| stData | output | 96 | Store slot, value zero-extended |
| stAck | input | 1 | Store accepted on this edge |
| cycleCost | output | 8 | Accumulated cycle cost of the command |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed |
| error | output | 1 | Command rejected |

## Verification
After `start` is accepted, the block spends one cycle fetching the list. It then spends one cycle on each list bit before that bit's request, and one cycle after the last bit before `done`. A rejected command raises `error` in the second cycle after `start`. The bench does not compute these cycle counts for each case. It samples on falling edges and waits for `done` or `error` with a bounded loop. It checks the whole store stream through a scoreboard queue that the monitor compares on every cycle a request is held. The bench checks that `done` has dropped on the falling edge after it was seen. It varies the acknowledge delay from 0 to 3 cycles, so the held-request rule is checked on cycles where the request waits.

// File: rtl/fpListPkg.sv
`timescale 1ns/1ps
package fpListPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LIST, S_SCAN, S_STORE, S_FIN, S_FAULT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCmd;     // capture command, base, clear index and cost
    logic ldMask;    // capture the resolved register list
    logic stepAddr;  // store accepted: advance address and cost
    logic stepIdx;   // move to next list bit
  } dpStrobe_t;
endpackage

// File: rtl/fpListDatapath.sv
`timescale 1ns/1ps
module fpListDatapath
  import fpListPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int D_W       = 32,
  parameter int FP_W      = 80,
  parameter int SLOT_W    = 96,
  parameter int NUM_REGS  = 8,
  parameter int STRIDE    = 12,
  parameter int COST_STEP = 2,
  parameter int COST_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strb,
  input  logic [15:0]                 cmdWord,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [D_W-1:0]              dRegData,
  input  logic [FP_W-1:0]             fpRegData,
  output logic [2:0]                  dRegSel,
  output logic [$clog2(NUM_REGS)-1:0] fpRegSel,
  output logic [ADDR_W-1:0]           stAddr,
  output logic [SLOT_W-1:0]           stData,
  output logic [COST_W-1:0]           cost,
  output logic                        curBit,
  output logic                        lastIdx,
  output logic                        badCmd
);
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int DIR_BIT = 13;
  localparam int MODE_LO = 11;
  localparam int DSEL_LO = 4;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_REGS - 1);

  logic [15:0]         cmdQ;
  logic [NUM_REGS-1:0] maskQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [IDX_W-1:0]    idxQ;
  logic [COST_W-1:0]   costQ;
  logic [1:0]          listMode;

  assign listMode = cmdQ[MODE_LO +: 2];
  assign badCmd   = !cmdQ[DIR_BIT] || (listMode == 2'd3);
  assign dRegSel  = cmdQ[DSEL_LO +: 3];
  assign fpRegSel = (listMode == 2'd2) ? (IDX_TOP - idxQ) : idxQ;
  assign curBit   = maskQ[idxQ];
  assign lastIdx  = (idxQ == IDX_TOP);
  assign stAddr   = addrQ;
  assign cost     = costQ;

  generate
    if (SLOT_W > FP_W) begin : g_pad
      assign stData = {{(SLOT_W-FP_W){1'b0}}, fpRegData};
    end else begin : g_nopad
      assign stData = fpRegData[SLOT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      maskQ <= '0;
      addrQ <= '0;
      idxQ  <= '0;
      costQ <= '0;
    end else begin
      if (strb.ldCmd) begin
        cmdQ  <= cmdWord;
        addrQ <= baseAddr;
        idxQ  <= '0;
        costQ <= '0;
      end
      if (strb.ldMask)
        maskQ <= (listMode == 2'd1) ? dRegData[NUM_REGS-1:0] : cmdQ[NUM_REGS-1:0];
      if (strb.stepAddr) begin
        addrQ <= addrQ + ADDR_W'(STRIDE);
        costQ <= costQ + COST_W'(COST_STEP);
      end
      if (strb.stepIdx)
        idxQ <= idxQ + 1'b1;
    end
  end

  // R3: the index only moves forward one bit at a time within a command
  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepIdx && !strb.ldCmd |=> idxQ == $past(idxQ) + 1'b1);
endmodule

// File: rtl/fpListControl.sv
`timescale 1ns/1ps
module fpListControl
  import fpListPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      curBit,
  input  logic      lastIdx,
  input  logic      badCmd,
  input  logic      stAck,
  output dpStrobe_t strb,
  output logic      stReq,
  output logic      busy,
  output logic      done,
  output logic      error
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    stReq     = 1'b0;
    done      = 1'b0;
    error     = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.ldCmd = 1'b1;
        nextState  = S_LIST;
      end
      S_LIST: begin
        if (badCmd) nextState = S_FAULT;
        else begin
          strb.ldMask = 1'b1;
          nextState   = S_SCAN;
        end
      end
      S_SCAN: begin
        if (curBit)       nextState = S_STORE;
        else if (lastIdx) nextState = S_FIN;
        else              strb.stepIdx = 1'b1;
      end
      S_STORE: begin
        stReq = 1'b1;
        if (stAck) begin
          strb.stepAddr = 1'b1;
          if (lastIdx) nextState = S_FIN;
          else begin
            strb.stepIdx = 1'b1;
            nextState    = S_SCAN;
          end
        end
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      S_FAULT: begin
        error     = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  p_req_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    stReq && !stAck |=> stReq);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/fpRegListStore.sv
`timescale 1ns/1ps
module fpRegListStore
  import fpListPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int D_W       = 32,
  parameter int FP_W      = 80,
  parameter int SLOT_W    = 96,
  parameter int NUM_REGS  = 8,
  parameter int STRIDE    = 12,
  parameter int COST_STEP = 2,
  parameter int COST_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [15:0]                 cmdWord,
  input  logic [ADDR_W-1:0]           baseAddr,
  output logic [2:0]                  dRegSel,
  input  logic [D_W-1:0]              dRegData,
  output logic [$clog2(NUM_REGS)-1:0] fpRegSel,
  input  logic [FP_W-1:0]             fpRegData,
  output logic                        stReq,
  output logic [ADDR_W-1:0]           stAddr,
  output logic [SLOT_W-1:0]           stData,
  input  logic                        stAck,
  output logic [COST_W-1:0]           cycleCost,
  output logic                        busy,
  output logic                        done,
  output logic                        error
);
  dpStrobe_t strb;
  logic curBit, lastIdx, badCmd;

  fpListControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .curBit(curBit),
    .lastIdx(lastIdx), .badCmd(badCmd), .stAck(stAck), .strb(strb),
    .stReq(stReq), .busy(busy), .done(done), .error(error)
  );

  fpListDatapath #(
    .ADDR_W(ADDR_W), .D_W(D_W), .FP_W(FP_W), .SLOT_W(SLOT_W),
    .NUM_REGS(NUM_REGS), .STRIDE(STRIDE), .COST_STEP(COST_STEP), .COST_W(COST_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWord(cmdWord), .baseAddr(baseAddr),
    .dRegData(dRegData), .fpRegData(fpRegData), .dRegSel(dRegSel),
    .fpRegSel(fpRegSel), .stAddr(stAddr), .stData(stData), .cost(cycleCost),
    .curBit(curBit), .lastIdx(lastIdx), .badCmd(badCmd)
  );

  p_hold_slot_r11: assert property (@(posedge clk) disable iff (!rstN)
    stReq && !stAck |=> $stable(stAddr) && $stable(stData));
  p_err_nocost_r9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> cycleCost == '0 && !stReq);
  p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stReq);
endmodule

// File: tb/fpRegListStore_test.sv
`timescale 1ns/1ps
module fpRegListStore_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0;
  logic [15:0] cmdWord = '0;
  logic [31:0] baseAddr = '0;
  logic [2:0]  dRegSel;
  logic [31:0] dRegData;
  logic [2:0]  fpRegSel;
  logic [79:0] fpRegData;
  logic        stReq;
  logic [31:0] stAddr;
  logic [95:0] stData;
  logic        stAck = 0;
  logic [7:0]  cycleCost;
  logic        busy, done, error;

  logic [31:0] dregs [8];
  int checks = 0, fails = 0;
  int ackDelay = 0, waitCnt = 0;
  string curTag = "R3";
  logic [31:0] expAddr [$];
  logic [2:0]  expReg  [$];
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [79:0] fpVal(input logic [2:0] i);
    return {16'h3F00 + 16'(i), 32'hA5A50000 + 32'(i) * 17, 32'h0F0F0000 + 32'(i) * 4099};
  endfunction

  assign fpRegData = fpVal(fpRegSel);
  assign dRegData  = dregs[dRegSel];

  fpRegListStore uut (
    .clk(clk), .rstN(rstN), .start(start), .cmdWord(cmdWord), .baseAddr(baseAddr),
    .dRegSel(dRegSel), .dRegData(dRegData), .fpRegSel(fpRegSel), .fpRegData(fpRegData),
    .stReq(stReq), .stAddr(stAddr), .stData(stData), .stAck(stAck),
    .cycleCost(cycleCost), .busy(busy), .done(done), .error(error)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every held request cycle against the queue front
  always @(negedge clk) begin
    if (!rstN) begin
      stAck = 0; waitCnt = 0;
    end else if (stReq) begin
      if (expAddr.size() == 0) begin
        check({curTag, " unexpected store"}, 128'(stAddr), 128'hDEAD);
        stAck = 1;
      end else begin
        if (waitCnt > 0) begin
          check("R11 held addr", 128'(stAddr), 128'(expAddr[0]));
          check("R11 held data", 128'(stData), {32'h0, 16'h0, fpVal(expReg[0])});
        end
        if (waitCnt >= ackDelay) begin
          check("R6 addr", 128'(stAddr), 128'(expAddr[0]));
          check({curTag, "/R7 data"}, 128'(stData), {32'h0, 16'h0, fpVal(expReg[0])});
          void'(expAddr.pop_front());
          void'(expReg.pop_front());
          stAck = 1; waitCnt = 0;
        end else begin
          stAck = 0; waitCnt++;
        end
      end
    end else begin
      stAck = 0; waitCnt = 0;
    end
  end

  task automatic runCmd(input string tag, input logic dir, input logic [1:0] mode,
                        input logic [7:0] low, input logic [31:0] base,
                        input int delay, input bit midStart);
    logic [7:0]  mask;
    logic [31:0] a;
    int n, guard;
    bit expErr;
    curTag = tag;
    ackDelay = delay;
    expErr = !dir || (mode == 2'd3);
    mask = (mode == 2'd1) ? dregs[low[6:4]][7:0] : low;
    a = base; n = 0;
    if (!expErr)
      for (int i = 0; i < 8; i++)
        if (mask[i]) begin
          expAddr.push_back(a);
          expReg.push_back((mode == 2'd2) ? 3'(7 - i) : 3'(i));
          a += 12; n++;
        end
    @(negedge clk);
    cmdWord  = {2'b00, dir, mode, 3'b000, low};
    baseAddr = base;
    start    = 1;
    @(negedge clk);
    start = 0;
    if (midStart) begin
      repeat (3) @(negedge clk);
      cmdWord = 16'h3800; baseAddr = 32'hFFFF0000; start = 1; // R12: ignored while busy
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (!(done || error) && guard < 400) begin
      @(negedge clk); guard++;
    end
    if (guard >= 400) check({tag, " watchdog"}, 0, 1);
    check({expErr ? "R9" : tag, " error flag"}, 128'(error), 128'(expErr));
    check("R12 excl", 128'(done && error), 0);
    check({tag, " stores left"}, 128'(expAddr.size()), 0);
    check("R8 cost", 128'(cycleCost), 128'(2 * n));
    expAddr.delete(); expReg.delete();
    @(negedge clk);
    check("R12 pulse", 128'(done | error), 0);
    check("R8 cost held", 128'(cycleCost), 128'(2 * n));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) dregs[i] = 32'h0;
    dregs[3] = 32'h0000_0081;
    dregs[5] = 32'hFFFF_FF00;
    repeat (3) @(negedge clk);
    check("R1 done",  128'(done), 0);
    check("R1 error", 128'(error), 0);
    check("R1 stReq", 128'(stReq), 0);
    check("R1 busy",  128'(busy), 0);
    rstN = 1;
    runCmd("R3", 1'b1, 2'd0, 8'hA5, 32'h0000_1000, 0, 0);
    runCmd("R4", 1'b1, 2'd2, 8'h0B, 32'h0000_2000, 2, 0);
    runCmd("R5", 1'b1, 2'd1, 8'h30, 32'h0000_3000, 1, 0);
    runCmd("R5", 1'b1, 2'd1, 8'h50, 32'h0000_3800, 0, 0);
    runCmd("R10", 1'b1, 2'd0, 8'h00, 32'h0000_4000, 0, 0);
    runCmd("R9", 1'b1, 2'd3, 8'hFF, 32'h0000_5000, 0, 0);
    runCmd("R9", 1'b0, 2'd0, 8'hFF, 32'h0000_6000, 0, 0);
    runCmd("R12", 1'b1, 2'd0, 8'hFF, 32'hFFFF_FFF0, 3, 1);
    runCmd("R2", 1'b1, 2'd2, 8'h80, 32'h0000_7000, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule